// File: doc/BRIEF.md
# Byte-Parallel CRC-8 Engine

This block keeps a running 8-bit cyclic redundancy check over a byte stream and absorbs one whole byte on each clock where the input is marked valid. The register value is XORed with the arriving byte, and that 8-bit result selects one entry of a 256-entry remainder table. The selected entry becomes the new register value. The table is computed during elaboration from the one-bit-at-a-time shift rule, so the block needs no data file.

The one-bit rule is as follows. The register shifts right, and each data byte is consumed least significant bit first. The feedback bit is the register's bit 0 XORed with the incoming bit. When the feedback bit is 1, the shifted register is XORed with 8'h8C. This is the same as XORing with 8'h18 before the shift and setting the top bit to 1.

A sender runs the bytes of a frame through the block and appends the register value as a trailing check byte. A receiver runs the whole frame, check byte included, through the block. If the frame arrived intact, the register ends at zero, and a zero flag reports this directly.

Top module: `crc8_byte_lut`

## Requirements
- R1: A synchronous clear (`clr` high at a rising clock edge) loads 8'h00 into the register on that edge. The clear wins over a valid byte presented in the same cycle.
- R2: On an edge where `clr` is low and `din_vld` is high, the register becomes T[crc XOR din]. T[k] is the result of eight one-bit steps on k, starting from 8'h00. Each step consumes bit 0 first, computes fb = reg[0] XOR bit, shifts the register right by one, and then XORs it with 8'h8C if fb is 1.
- R3: On an edge where both `clr` and `din_vld` are low, the register keeps its value.
- R4: `crc_zero` is high in exactly the cycles in which `crc` equals 8'h00, with no added clock delay.
- R5: Starting from 8'h00, the bytes 1, 2, 3, 15, 16, 17 and 23 produce 5E, BC, E2, 41, 9D, C3 and 1E respectively.
- R6: Absorbing a byte equal to the current register value leaves the register at 8'h00. So a frame followed by its own check byte ends with `crc_zero` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of the register to 8'h00 |
| din | input | 8 | Byte to absorb |
| din_vld | input | 1 | `din` is absorbed on this edge |
| crc | output | 8 | Current register value |
| crc_zero | output | 1 | High while `crc` is 8'h00 |

## Verification
A clear and a valid byte can land on the same edge. In that case the clear must win and the byte must be lost. The random stimulus raises `clr` and `din_vld` independently, so this collision happens many times, and it is also driven once on purpose with a byte that would otherwise give a nonzero result. On every edge, the bench's one-bit model applies the clear first. It then compares both `crc` and `crc_zero` against that model in the half cycle after the edge.

// File: rtl/crc8_byte_lut.sv
module crc8_byte_lut #(
  parameter int          W    = 8,
  parameter logic [W-1:0] FB  = 8'h8C,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] din,
  input  logic         din_vld,
  output logic [W-1:0] crc,
  output logic         crc_zero
);
  localparam int N = 1 << W;

  function automatic logic [W-1:0] remainder(input logic [W-1:0] k);
    logic [W-1:0] r;
    logic         f;
    r = '0;
    for (int b = 0; b < W; b++) begin
      f = r[0] ^ k[b];
      r = r >> 1;
      if (f) r = r ^ FB;
    end
    return r;
  endfunction

  logic [W-1:0] lut [N];
  logic [W-1:0] crc_q;

  for (genvar i = 0; i < N; i++) begin : g_lut
    assign lut[i] = remainder(W'(i));
  end

  always_ff @(posedge clk) begin
    if (clr)          crc_q <= INIT;
    else if (din_vld) crc_q <= lut[crc_q ^ din];
  end

  assign crc      = crc_q;
  assign crc_zero = (crc_q == '0);

  AST_CLEAR_WINS: assert property (@(posedge clk) $past(clr) |-> crc_q == INIT); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr) !din_vld |=> $stable(crc_q)); // R3
  AST_SELF_RESIDUE: assert property (@(posedge clk) disable iff (clr) (din_vld && din == crc_q) |=> crc_zero); // R6
  AST_FLAG_AFTER_CLR: assert property (@(posedge clk) $past(clr) |-> crc_zero); // R4
endmodule

// File: tb/sim_crc8_byte_lut.sv
module sim_crc8_byte_lut;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic [7:0] din = 8'h00;
  logic       din_vld = 1'b0;
  logic [7:0] crc;
  logic       crc_zero;
  logic [7:0] exp_crc = 8'h00;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  crc8_byte_lut u0 (.clk(clk), .clr(clr), .din(din), .din_vld(din_vld),
                    .crc(crc), .crc_zero(crc_zero));

  function automatic logic [7:0] ser_byte(input logic [7:0] r0, input logic [7:0] d);
    logic [7:0] r;
    logic       f;
    r = r0;
    for (int b = 0; b < 8; b++) begin
      f = r[0] ^ d[b];
      if (f) r = ((r ^ 8'h18) >> 1) | 8'h80;
      else   r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic v, input logic [7:0] d, input string req);
    clr = c; din_vld = v; din = d;
    @(posedge clk);
    if (c) exp_crc = 8'h00;
    else if (v) exp_crc = ser_byte(exp_crc, d);
    @(negedge clk);
    check(req, crc, exp_crc);
    check("R4", {7'b0, crc_zero}, {7'b0, exp_crc == 8'h00});
  endtask

  initial begin
    logic [7:0] kv [14];
    logic [7:0] frame [7];
    logic [7:0] cb;
    kv = '{8'd1,8'h5E, 8'd2,8'hBC, 8'd3,8'hE2, 8'd15,8'h41, 8'd16,8'h9D, 8'd17,8'hC3, 8'd23,8'h1E};
    void'($urandom(32'd1234));
    @(negedge clk);
    step(1'b1, 1'b0, 8'h00, "R1");
    check("R1 reset", crc, 8'h00);
    for (int i = 0; i < 7; i++) begin
      step(1'b1, 1'b0, 8'h00, "R1");
      step(1'b0, 1'b1, kv[2*i], "R5");
      check("R5 table", crc, kv[2*i+1]);
    end
    step(1'b0, 1'b0, 8'hFF, "R3 hold");
    step(1'b1, 1'b1, 8'h01, "R1 clear beats valid");
    for (int f = 0; f < 20; f++) begin
      step(1'b1, 1'b0, 8'h00, "R1");
      for (int i = 0; i < 7; i++) begin
        frame[i] = 8'($urandom);
        step(1'b0, 1'b1, frame[i], "R2");
      end
      cb = crc;
      step(1'b0, 1'b0, 8'h00, "R3");
      step(1'b0, 1'b1, cb, "R6 residue");
      check("R6 zero flag", {7'b0, crc_zero}, 8'h01);
    end
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 16) == 0, ($urandom % 3) != 0, 8'($urandom), "R2/R3 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule